// File: doc/BRIEF.md
# Stepped Sequence LUT Player

The block plays a table of output steps from a small ring buffer. Software fills the ring through a write port and publishes a write pointer that marks the first entry not yet refilled. While the acquisition trigger is high, the player reads one entry and holds it for a programmable number of sample clocks. It then moves to the next entry and wraps at the end of the ring. A rising trigger restarts playback at address 0.

Each entry carries a sequence value for each of the two analog channels, an 8-bit density level for each of four pulse-density digital outputs, and three flags. The flags mute the step, request a ramp-down of the downstream amplitude, or request a resync of the waveform generators. A first-order accumulator modulator turns each density level into a bit stream. If the player reaches the write pointer before software has moved it on, the player repeats the current step, counts one lost step, and sets a sticky status.

Top module: `seq_lut_player`

## Requirements
- R1: After reset, all outputs are 0: sequence values, PDM bits, the three flag outputs, rd_ptr_o, lost_o and lost_cnt_o.
- R2: When trig_i is sampled high after being low, the entry at address 0 appears on the outputs in the next cycle. At that point rd_ptr_o is 0 and lost_o and lost_cnt_o are cleared.
- R3: Each step lasts div_i clock cycles, and a div_i of 0 is treated as 1. The read pointer then advances by one and wraps from 2^ADDR_W-1 to 0.
- R4: The entry layout is as follows. Bits [15:0] hold the channel 0 value and bits [31:16] hold the channel 1 value. PDM level k sits at bits [39+8k:32+8k]. Bit 64 is the mute flag, bit 65 is the ramp-down flag and bit 66 is the resync flag. seq_o[15:0] and seq_o[31:16] carry the channel values of the current step.
- R5: During a step with the mute flag set, zero_o is 1 and all sequence values and PDM bits are 0 for every cycle of the step.
- R6: During a step with the resync flag set, resync_o is 1 and all sequence values and PDM bits are 0.
- R7: ramp_down_o sets when a step with the ramp-down flag is loaded. It stays set through later steps until trig_i is low, and it clears in the cycle after that.
- R8: At the end of a step, if the next address equals wr_ptr_i, the read pointer holds and the current entry repeats for another step. lost_cnt_o increments once for each such step and saturates at its maximum. lost_o is set and stays set until the next start.
- R9: On each PDM output, with a constant level L and no mute, any 256 consecutive cycles contain exactly L ones.
- R10: One cycle after trig_i is sampled low, the player stops and all sequence values and PDM bits are 0.
- R11: If a write lands on the address being fetched in the same cycle as a step advance, the step shows the old contents. The new contents are stored for later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Acquisition trigger; playback runs while high |
| div_i | input | DIV_W | Sample clocks per step (0 acts as 1) |
| wr_en_i | input | 1 | Ring write strobe |
| wr_addr_i | input | ADDR_W | Ring write address |
| wr_data_i | input | 67 | Step entry to write |
| wr_ptr_i | input | ADDR_W | First entry not yet refilled by software |
| seq_o | output | 32 | Sequence values, channel 1 in the upper half |
| pdm_o | output | 4 | Pulse-density digital outputs |
| zero_o | output | 1 | Current step is muted |
| ramp_down_o | output | 1 | Latched ramp-down request |
| resync_o | output | 1 | Current step requests a resync |
| rd_ptr_o | output | ADDR_W | Address of the entry being played |
| lost_o | output | 1 | Sticky lost-step status |
| lost_cnt_o | output | CNT_W | Saturating lost-step count |

## Verification
Two events can fall in the same cycle: a step advance, and a software write to the address that the advance fetches. The bench provokes this by timing a write strobe onto the exact edge that ends a two-cycle step. It then checks that the new step shows the stale value, and that a later restart reads back the new value. A second collision is between a step boundary and a write-pointer update. The bench starves the player, moves wr_ptr_i while the player is stalled, and checks the held pointer, the lost count, and the wrap across address 0.

// File: rtl/seq_lut_pkg.sv
package seq_lut_pkg;
  localparam int DAC_W = 16;
  localparam int N_DAC = 2;
  localparam int PDM_W = 8;
  localparam int N_PDM = 4;

  // field order fixes the bit positions software writes
  typedef struct packed {
    logic                          resync;
    logic                          ramp_dn;
    logic                          zero;
    logic [N_PDM-1:0][PDM_W-1:0]   pdm;
    logic [N_DAC-1:0][DAC_W-1:0]   dac;
  } step_t;

  localparam int STEP_W = $bits(step_t);
endpackage

// File: rtl/seq_lut_mem.sv
module seq_lut_mem
  import seq_lut_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  step_t             wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output step_t             rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  step_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  // read before write on a same-address collision
  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/seq_step_timer.sv
module seq_step_timer #(
  parameter int ADDR_W = 4,
  parameter int DIV_W  = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [ADDR_W-1:0] wr_ptr_i,
  output logic              run_o,
  output logic              start_o,
  output logic              load_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [ADDR_W-1:0] rd_ptr_o,
  output logic              lost_o,
  output logic [CNT_W-1:0]  lost_cnt_o
);
  logic              run_q;
  logic [DIV_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] rd_ptr_q;
  logic              lost_q;
  logic [CNT_W-1:0]  lost_cnt_q;

  logic [DIV_W-1:0]  div_last;
  logic [ADDR_W-1:0] nxt;
  logic              start, tick, stall, adv;

  assign div_last = (div_i == '0) ? '0 : div_i - 1'b1;
  assign nxt      = rd_ptr_q + 1'b1;
  assign start    = trig_i & ~run_q;
  assign tick     = run_q & trig_i & (cnt_q >= div_last);
  assign stall    = tick & (nxt == wr_ptr_i);
  assign adv      = tick & ~stall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= 1'b0;
      cnt_q      <= '0;
      rd_ptr_q   <= '0;
      lost_q     <= 1'b0;
      lost_cnt_q <= '0;
    end else begin
      run_q <= trig_i;
      if (start) begin
        cnt_q      <= '0;
        rd_ptr_q   <= '0;
        lost_q     <= 1'b0;
        lost_cnt_q <= '0;
      end else if (run_q && trig_i) begin
        cnt_q <= tick ? '0 : cnt_q + 1'b1;
        if (adv) rd_ptr_q <= nxt;
        if (stall) begin
          lost_q <= 1'b1;
          if (lost_cnt_q != '1) lost_cnt_q <= lost_cnt_q + 1'b1;
        end
      end
    end
  end

  assign run_o        = run_q;
  assign start_o      = start;
  assign load_o       = start | adv;
  assign fetch_addr_o = start ? '0 : nxt;
  assign rd_ptr_o     = rd_ptr_q;
  assign lost_o       = lost_q;
  assign lost_cnt_o   = lost_cnt_q;

  // R2
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (rd_ptr_q == '0) && (cnt_q == '0) && !lost_q && (lost_cnt_q == '0));
  // R3
  adv_not_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv |=> rd_ptr_q != $past(wr_ptr_i));
  // R8
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall |=> (rd_ptr_q == $past(rd_ptr_q)) && lost_q);
  // R8
  lost_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lost_q && !start) |=> lost_q);
  // R10
  stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_i |=> !run_q);
endmodule

// File: rtl/seq_pdm_mod.sv
module seq_pdm_mod #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] level_i,
  output logic         bit_o
);
  logic [W-1:0] acc_q;
  logic         bit_q;
  logic [W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, level_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      bit_q <= 1'b0;
    end else if (clr_i) begin
      acc_q <= '0;
      bit_q <= 1'b0;
    end else if (en_i) begin
      {bit_q, acc_q} <= sum;
    end else begin
      bit_q <= 1'b0;
    end
  end

  assign bit_o = bit_q;

  // R9
  pdm_zero_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && level_i == '0) |=> !bit_o);
endmodule

// File: rtl/seq_lut_player.sv
module seq_lut_player
  import seq_lut_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DIV_W  = 16,
  parameter int CNT_W  = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     trig_i,
  input  logic [DIV_W-1:0]         div_i,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [STEP_W-1:0]        wr_data_i,
  input  logic [ADDR_W-1:0]        wr_ptr_i,
  output logic [N_DAC*DAC_W-1:0]   seq_o,
  output logic [N_PDM-1:0]         pdm_o,
  output logic                     zero_o,
  output logic                     ramp_down_o,
  output logic                     resync_o,
  output logic [ADDR_W-1:0]        rd_ptr_o,
  output logic                     lost_o,
  output logic [CNT_W-1:0]         lost_cnt_o
);
  step_t             wr_step, rd_step, cur_q;
  logic              run, start, load;
  logic [ADDR_W-1:0] fetch_addr;
  logic              ramp_q;
  logic              live;
  logic [N_PDM-1:0]  pdm_raw;

  assign wr_step = wr_data_i;

  seq_lut_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_step),
    .rd_addr_i (fetch_addr),
    .rd_data_o (rd_step)
  );

  seq_step_timer #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .trig_i       (trig_i),
    .div_i        (div_i),
    .wr_ptr_i     (wr_ptr_i),
    .run_o        (run),
    .start_o      (start),
    .load_o       (load),
    .fetch_addr_o (fetch_addr),
    .rd_ptr_o     (rd_ptr_o),
    .lost_o       (lost_o),
    .lost_cnt_o   (lost_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      ramp_q <= 1'b0;
    end else begin
      if (load) cur_q <= rd_step;
      if (!trig_i) ramp_q <= 1'b0;
      else if (load && rd_step.ramp_dn) ramp_q <= 1'b1;
    end
  end

  assign live = run & ~cur_q.zero & ~cur_q.resync;

  for (genvar i = 0; i < N_DAC; i++) begin : g_dac
    assign seq_o[i*DAC_W +: DAC_W] = live ? cur_q.dac[i] : '0;
  end

  for (genvar k = 0; k < N_PDM; k++) begin : g_pdm
    seq_pdm_mod #(.W(PDM_W)) u_pdm (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (start | ~run),
      .en_i    (live),
      .level_i (cur_q.pdm[k]),
      .bit_o   (pdm_raw[k])
    );
    assign pdm_o[k] = pdm_raw[k] & live;
  end

  assign zero_o      = run & cur_q.zero;
  assign resync_o    = run & cur_q.resync;
  assign ramp_down_o = ramp_q;

  // R7
  ramp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ramp_down_o) |-> !$past(trig_i));
  // R5
  mute_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o || resync_o) |-> (seq_o == '0) && (pdm_o == '0));
  // R10
  idle_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_i |=> (seq_o == '0) && (pdm_o == '0) && !zero_o && !resync_o);
endmodule

// File: tb/sim_seq_lut_player.sv
module sim_seq_lut_player;
  localparam int ADDR_W = 4;
  localparam int DIV_W  = 16;
  localparam int CNT_W  = 8;
  localparam int EW     = 67;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              trig_i = 1'b0;
  logic [DIV_W-1:0]  div_i = '0;
  logic              wr_en_i = 1'b0;
  logic [ADDR_W-1:0] wr_addr_i = '0;
  logic [EW-1:0]     wr_data_i = '0;
  logic [ADDR_W-1:0] wr_ptr_i = '0;
  logic [31:0]       seq_o;
  logic [3:0]        pdm_o;
  logic              zero_o, ramp_down_o, resync_o, lost_o;
  logic [ADDR_W-1:0] rd_ptr_o;
  logic [CNT_W-1:0]  lost_cnt_o;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  seq_lut_player #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .trig_i(trig_i), .div_i(div_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .wr_ptr_i(wr_ptr_i), .seq_o(seq_o), .pdm_o(pdm_o), .zero_o(zero_o),
    .ramp_down_o(ramp_down_o), .resync_o(resync_o), .rd_ptr_o(rd_ptr_o),
    .lost_o(lost_o), .lost_cnt_o(lost_cnt_o)
  );

  // rows: {div, ch0 value, ch1 value}
  localparam logic [47:0] VEC [5] = '{
    {16'd1, 16'h1234, 16'hABCD},
    {16'd2, 16'h0001, 16'h8000},
    {16'd3, 16'hFFFF, 16'h0000},
    {16'd7, 16'h5A5A, 16'hA5A5},
    {16'd0, 16'h0F0F, 16'hF0F0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [EW-1:0] mk(input logic [2:0] fl, input logic [31:0] lv,
                                        input logic [15:0] d1, input logic [15:0] d0);
    return {fl, lv, d1, d0};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [EW-1:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic start_run;
    trig_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic stop_run;
    trig_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(2);
    // R1 reset state
    chk("R1 seq", {32'd0, seq_o}, 64'd0);
    chk("R1 pdm", {60'd0, pdm_o}, 64'd0);
    chk("R1 flags", {61'd0, zero_o, ramp_down_o, resync_o}, 64'd0);
    chk("R1 rd_ptr", {60'd0, rd_ptr_o}, 64'd0);
    chk("R1 lost", {55'd0, lost_cnt_o, lost_o}, 64'd0);

    // table walk: R2 R3 R4 R10
    foreach (VEC[i]) begin
      logic [15:0] dv, a0, a1;
      int de;
      {dv, a0, a1} = VEC[i];
      de = (dv == 0) ? 1 : int'(dv);
      div_i = dv;
      wr(0, mk(3'b000, 32'd0, a1, a0));
      wr(1, mk(3'b000, 32'd0, ~a1, ~a0));
      wr_ptr_i = 4'd5;
      start_run();
      chk("R2 first entry", {32'd0, seq_o}, {32'd0, a1, a0});
      chk("R2 rd_ptr", {60'd0, rd_ptr_o}, 64'd0);
      tick(de - 1);
      chk("R3 step length", {32'd0, seq_o}, {32'd0, a1, a0});
      tick(1);
      chk("R4 next entry", {32'd0, seq_o}, {32'd0, ~a1, ~a0});
      chk("R3 advance", {60'd0, rd_ptr_o}, 64'd1);
      stop_run();
      chk("R10 stopped", {28'd0, pdm_o, seq_o}, 64'd0);
    end

    // flags: R5 R6 R7
    div_i = 16'd4;
    wr(0, mk(3'b000, 32'hFFFF_FFFF, 16'h2222, 16'h1111));
    wr(1, mk(3'b001, 32'hFFFF_FFFF, 16'h2222, 16'h1111));
    wr(2, mk(3'b100, 32'hFFFF_FFFF, 16'h2222, 16'h1111));
    wr(3, mk(3'b010, 32'hFFFF_FFFF, 16'h4444, 16'h3333));
    wr(4, mk(3'b000, 32'hFFFF_FFFF, 16'h6666, 16'h5555));
    wr_ptr_i = 4'd6;
    start_run();
    chk("R4 seq", {32'd0, seq_o}, 64'h2222_1111);
    chk("R5 no mute", {63'd0, zero_o}, 64'd0);
    tick(4);
    for (int k = 0; k < 4; k++) begin
      chk("R5 mute seq", {28'd0, pdm_o, seq_o}, 64'd0);
      chk("R5 zero_o", {63'd0, zero_o}, 64'd1);
      tick(1);
    end
    chk("R6 resync_o", {63'd0, resync_o}, 64'd1);
    chk("R6 resync mute", {28'd0, pdm_o, seq_o}, 64'd0);
    tick(4);
    chk("R7 ramp set", {63'd0, ramp_down_o}, 64'd1);
    chk("R7 seq", {32'd0, seq_o}, 64'h4444_3333);
    tick(4);
    chk("R7 ramp held", {63'd0, ramp_down_o}, 64'd1);
    chk("R6 resync clear", {63'd0, resync_o}, 64'd0);
    chk("R4 seq e4", {32'd0, seq_o}, 64'h6666_5555);
    stop_run();
    chk("R7 ramp cleared", {63'd0, ramp_down_o}, 64'd0);

    // underrun: R8, then R2 clears status
    div_i = 16'd3;
    wr(0, mk(3'b000, 32'd0, 16'h0000, 16'h00A0));
    wr(1, mk(3'b000, 32'd0, 16'h0000, 16'h00A1));
    wr_ptr_i = 4'd2;
    start_run();
    tick(3);
    chk("R8 e1", {32'd0, seq_o}, 64'h00A1);
    chk("R8 no loss yet", {63'd0, lost_o}, 64'd0);
    tick(3);
    chk("R8 hold ptr", {60'd0, rd_ptr_o}, 64'd1);
    chk("R8 repeat", {32'd0, seq_o}, 64'h00A1);
    chk("R8 lost", {55'd0, lost_cnt_o, lost_o}, {55'd0, 8'd1, 1'b1});
    tick(3);
    chk("R8 count 2", {56'd0, lost_cnt_o}, 64'd2);
    wr_ptr_i = 4'd3;
    wr(2, mk(3'b000, 32'd0, 16'h0000, 16'h00A2));
    tick(2);
    chk("R8 resume", {32'd0, seq_o}, 64'h00A2);
    chk("R8 sticky", {55'd0, lost_cnt_o, lost_o}, {55'd0, 8'd2, 1'b1});
    stop_run();
    start_run();
    chk("R2 status cleared", {55'd0, lost_cnt_o, lost_o}, 64'd0);
    stop_run();

    // wrap with starvation: R3 R8
    div_i = 16'd1;
    for (int a = 0; a < 16; a++) wr(a[3:0], mk(3'b000, 32'd0, 16'd0, 16'h0100 + 16'(a)));
    wr_ptr_i = 4'd15;
    start_run();
    tick(14);
    chk("R3 ptr 14", {60'd0, rd_ptr_o}, 64'd14);
    tick(1);
    chk("R8 stall at 14", {60'd0, rd_ptr_o}, 64'd14);
    wr_ptr_i = 4'd3;
    tick(1);
    chk("R3 ptr 15", {32'd0, seq_o}, 64'h010F);
    tick(1);
    chk("R3 wrap to 0", {60'd0, rd_ptr_o}, 64'd0);
    chk("R3 wrap seq", {32'd0, seq_o}, 64'h0100);
    tick(2);
    chk("R3 ptr 2", {60'd0, rd_ptr_o}, 64'd2);
    tick(1);
    chk("R8 stall at 2", {60'd0, rd_ptr_o}, 64'd2);
    stop_run();

    // PDM density: R9
    div_i = 16'd400;
    wr(0, mk(3'b000, {8'd200, 8'd128, 8'd1, 8'd0}, 16'd0, 16'd0));
    wr_ptr_i = 4'd1;
    start_run();
    tick(5);
    begin
      int c [4];
      for (int k = 0; k < 4; k++) c[k] = 0;
      for (int s = 0; s < 256; s++) begin
        for (int k = 0; k < 4; k++) c[k] += int'(pdm_o[k]);
        tick(1);
      end
      chk("R9 level 0", 64'(c[0]), 64'd0);
      chk("R9 level 1", 64'(c[1]), 64'd1);
      chk("R9 level 128", 64'(c[2]), 64'd128);
      chk("R9 level 200", 64'(c[3]), 64'd200);
    end
    stop_run();

    // write colliding with fetch: R11
    div_i = 16'd2;
    for (int a = 0; a < 4; a++) wr(a[3:0], mk(3'b000, 32'd0, 16'd0, 16'h0A00 + 16'(a)));
    wr_ptr_i = 4'd8;
    start_run();
    tick(1);
    wr(1, mk(3'b000, 32'd0, 16'd0, 16'hBEEF));
    chk("R11 old content", {32'd0, seq_o}, 64'h0A01);
    stop_run();
    div_i = 16'd1;
    start_run();
    tick(1);
    chk("R11 new content", {32'd0, seq_o}, 64'hBEEF);
    stop_run();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule